// File: doc/BRIEF.md
# Bridge Memory Window Forwarding Decoder

This block makes the claim decision for memory transactions on both sides of a PCI-to-PCI bridge. It holds two programmable address windows, one for non-prefetchable and one for prefetchable memory, and applies them in opposite senses depending on the side. On the primary (upstream-facing) side, an access is claimed and sent downstream only when it hits a window. On the secondary side, an access is claimed and sent upstream only when it misses both windows. A legacy display range override, an unconditional upstream path for 64-bit dual-address accesses and a primary memory-enable gate change this basic rule.

For each claimed access the decoder reports whether the target space is prefetchable. It also rewrites the command where needed: multi-line reads toward non-prefetchable space become plain reads, and write-and-invalidate becomes plain write when the requester flags that the cache-line conditions do not hold. Accesses whose low address bits select a non-linear burst order are marked for disconnect after the first data phase. Every result appears on registered outputs in the cycle after the request strobe.

Top module: `mem_fwd_decoder`

## Requirements
- R1: A primary-side (req_side=0) single-address memory access is claimed with dec_down=1 when its address hits the non-prefetchable window or the prefetchable window and mem_en=1.
- R2: A secondary-side (req_side=1) memory access whose address misses both windows is claimed with dec_down=0, and one that hits either window is not claimed.
- R3: A secondary-side access with req_dac=1 is always claimed upstream, whatever the windows hold; a primary-side access with req_dac=1 is never claimed.
- R4: With mem_en=0 no primary-side access is claimed, while secondary-side decoding is unchanged.
- R5: A window whose limit field is below its base field matches no address. After reset both windows hold base 0xFFF and limit 0x000, so nothing is claimed on the primary side and all secondary memory traffic goes upstream.
- R6: With vga_en=1, addresses 0x000A0000 to 0x000BFFFF are always claimed from the primary side and never claimed from the secondary side (single-address accesses).
- R7: dec_pref for a downstream claim is 1 only when the address hits the prefetchable window and neither the non-prefetchable window nor the enabled display range. For an upstream claim it is the inverse of up_nonpf.
- R8: A claimed Memory Read Multiple (4'hC) or Memory Read Line (4'hE) whose target is non-prefetchable (dec_pref=0) is output as Memory Read (4'h6); otherwise the command passes unchanged.
- R9: A claimed Memory Write and Invalidate (4'hF) is output as Memory Write (4'h7) when mwi_fallback=1 and unchanged otherwise.
- R10: dec_disc is 1 exactly when the access is claimed and req_addr[1:0] is not 2'b00.
- R11: Results are registered: dec_valid follows req_valid by one clock. Without a request, all outputs are zero. Only commands 4'h6, 4'h7, 4'hC, 4'hE and 4'hF count as memory commands; any other command is not claimed and is output unchanged.
- R12: Window registers hold address bits [31:20] and are written with cfg_wr_en=1 and cfg_sel 0 (non-prefetchable base), 1 (non-prefetchable limit), 2 (prefetchable base) or 3 (prefetchable limit). An address hits when its bits [31:20] lie between base and limit, both bounds inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Window register write strobe |
| cfg_sel | input | 2 | Window register select |
| cfg_wdata | input | 12 | Window field value (address bits 31:20) |
| mem_en | input | 1 | Primary memory response enable |
| vga_en | input | 1 | Legacy display range override enable |
| up_nonpf | input | 1 | Treat upstream claims as non-prefetchable |
| req_valid | input | 1 | Address phase strobe |
| req_side | input | 1 | 0 primary, 1 secondary |
| req_dac | input | 1 | Dual-address (64-bit) access |
| req_addr | input | 32 | Access address (low 32 bits) |
| req_cmd | input | 4 | Bus command |
| mwi_fallback | input | 1 | Cache-line conditions for write-and-invalidate not met |
| dec_valid | output | 1 | Registered result valid |
| dec_claim | output | 1 | Access is claimed and forwarded |
| dec_down | output | 1 | 1 downstream, 0 upstream |
| dec_pref | output | 1 | Forwarded target is prefetchable |
| dec_cmd | output | 4 | Command to issue on the far side |
| dec_disc | output | 1 | Disconnect after first data phase |

## Verification
A corrupted window register shows at the ports on the first request whose bits [31:20] fall between the correct and the wrong bound. The same request then shows a flipped claim on the primary side and the opposite flip on the secondary side, one clock after the strobe. Requests are therefore placed on both sides of every programmed edge, and each is repeated from both sides. A wrong priority between windows or the display range shows only in dec_pref and in the read command rewrite, so overlapping hits are issued with multi-line read commands.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef logic [3:0] pci_cmd_t;

    localparam pci_cmd_t CMD_MRD = 4'h6;
    localparam pci_cmd_t CMD_MWR = 4'h7;
    localparam pci_cmd_t CMD_MRM = 4'hC;
    localparam pci_cmd_t CMD_MRL = 4'hE;
    localparam pci_cmd_t CMD_MWI = 4'hF;

    typedef enum logic [1:0] {
        SEL_NP_BASE = 2'd0,
        SEL_NP_LIM  = 2'd1,
        SEL_PF_BASE = 2'd2,
        SEL_PF_LIM  = 2'd3
    } win_sel_e;

    typedef struct packed {
        logic     valid;
        logic     claim;
        logic     down;
        logic     pref;
        pci_cmd_t cmd;
        logic     disc;
    } dec_res_t;

    function automatic logic is_mem_cmd(input pci_cmd_t c);
        return (c == CMD_MRD) || (c == CMD_MWR) || (c == CMD_MRM) ||
               (c == CMD_MRL) || (c == CMD_MWI);
    endfunction

endpackage

// File: rtl/win_range.sv
module win_range #(
    parameter int WIN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_base,
    input  logic             wr_limit,
    input  logic [WIN_W-1:0] wdata,
    input  logic [WIN_W-1:0] addr_hi,
    output logic             hit
);
    typedef struct packed {
        logic [WIN_W-1:0] base;
        logic [WIN_W-1:0] limit;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (wr_base)  win_d.base  = wdata;
        if (wr_limit) win_d.limit = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q.base  <= '1;
            win_q.limit <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    // inclusive at both ends; an inverted pair can never satisfy both
    assign hit = (addr_hi >= win_q.base) && (addr_hi <= win_q.limit);

endmodule

// File: rtl/fwd_route.sv
module fwd_route #(
    parameter int          ADDR_W = 32,
    parameter logic [31:0] VGA_LO = 32'h000A_0000,
    parameter logic [31:0] VGA_HI = 32'h000B_FFFF
) (
    input  logic              side,
    input  logic              dac,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_cmd,
    input  logic              mem_en,
    input  logic              vga_en,
    input  logic              up_nonpf,
    input  logic              np_hit,
    input  logic              pf_hit,
    output logic              claim,
    output logic              down,
    output logic              pref
);
    logic vga_hit;
    logic any_win;

    always_comb begin
        vga_hit = vga_en && (addr >= ADDR_W'(VGA_LO)) && (addr <= ADDR_W'(VGA_HI));
        any_win = np_hit || pf_hit || vga_hit;
        claim   = 1'b0;
        down    = 1'b0;
        pref    = 1'b0;
        if (mem_cmd) begin
            if (!side) begin
                claim = !dac && mem_en && any_win;
                down  = claim;
                pref  = claim && pf_hit && !np_hit && !vga_hit;
            end else begin
                claim = dac || !any_win;
                pref  = claim && !up_nonpf;
            end
        end
    end

endmodule

// File: rtl/fwd_cmd_xlate.sv
module fwd_cmd_xlate
    import fwd_pkg::*;
(
    input  pci_cmd_t cmd_in,
    input  logic     claim,
    input  logic     pref,
    input  logic     mwi_fallback,
    output pci_cmd_t cmd_out
);
    always_comb begin
        cmd_out = cmd_in;
        if (claim) begin
            if (!pref && (cmd_in == CMD_MRM || cmd_in == CMD_MRL)) cmd_out = CMD_MRD;
            if (mwi_fallback && cmd_in == CMD_MWI)                 cmd_out = CMD_MWR;
        end
    end

endmodule

// File: rtl/mem_fwd_decoder.sv
module mem_fwd_decoder
    import fwd_pkg::*;
#(
    parameter int          ADDR_W = 32,
    parameter int          WIN_W  = 12,
    parameter logic [31:0] VGA_LO = 32'h000A_0000,
    parameter logic [31:0] VGA_HI = 32'h000B_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_sel,
    input  logic [WIN_W-1:0]  cfg_wdata,
    input  logic              mem_en,
    input  logic              vga_en,
    input  logic              up_nonpf,
    input  logic              req_valid,
    input  logic              req_side,
    input  logic              req_dac,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_cmd,
    input  logic              mwi_fallback,
    output logic              dec_valid,
    output logic              dec_claim,
    output logic              dec_down,
    output logic              dec_pref,
    output logic [3:0]        dec_cmd,
    output logic              dec_disc
);
    localparam int NUM_WIN = 2;
    localparam int HI_LSB  = ADDR_W - WIN_W;

    logic [NUM_WIN-1:0] win_hit;
    logic               rt_claim, rt_down, rt_pref;
    pci_cmd_t           xl_cmd;
    dec_res_t           res_d, res_q;

    // window 0 non-prefetchable, window 1 prefetchable; cfg_sel[1] picks the window
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        win_range #(.WIN_W(WIN_W)) u_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_base  (cfg_wr_en && (cfg_sel[1] == g[0]) && !cfg_sel[0]),
            .wr_limit (cfg_wr_en && (cfg_sel[1] == g[0]) &&  cfg_sel[0]),
            .wdata    (cfg_wdata),
            .addr_hi  (req_addr[ADDR_W-1:HI_LSB]),
            .hit      (win_hit[g])
        );
    end

    fwd_route #(.ADDR_W(ADDR_W), .VGA_LO(VGA_LO), .VGA_HI(VGA_HI)) u_route (
        .side     (req_side),
        .dac      (req_dac),
        .addr     (req_addr),
        .mem_cmd  (is_mem_cmd(req_cmd)),
        .mem_en   (mem_en),
        .vga_en   (vga_en),
        .up_nonpf (up_nonpf),
        .np_hit   (win_hit[0]),
        .pf_hit   (win_hit[1]),
        .claim    (rt_claim),
        .down     (rt_down),
        .pref     (rt_pref)
    );

    fwd_cmd_xlate u_xlate (
        .cmd_in       (req_cmd),
        .claim        (rt_claim),
        .pref         (rt_pref),
        .mwi_fallback (mwi_fallback),
        .cmd_out      (xl_cmd)
    );

    always_comb begin
        res_d = '0;
        if (req_valid) begin
            res_d.valid = 1'b1;
            res_d.claim = rt_claim;
            res_d.down  = rt_down;
            res_d.pref  = rt_pref;
            res_d.cmd   = xl_cmd;
            res_d.disc  = rt_claim && (req_addr[1:0] != 2'b00);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign dec_valid = res_q.valid;
    assign dec_claim = res_q.claim;
    assign dec_down  = res_q.down;
    assign dec_pref  = res_q.pref;
    assign dec_cmd   = res_q.cmd;
    assign dec_disc  = res_q.disc;

endmodule

// File: rtl/fwd_decoder_chk.sv
module fwd_decoder_chk
    import fwd_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        mem_en,
    input logic        vga_en,
    input logic        up_nonpf,
    input logic        req_valid,
    input logic        req_side,
    input logic        req_dac,
    input logic [31:0] req_addr,
    input logic [3:0]  req_cmd,
    input logic        dec_valid,
    input logic        dec_claim,
    input logic        dec_down,
    input logic        dec_pref,
    input logic [3:0]  dec_cmd,
    input logic        dec_disc
);
    // R11
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dec_valid);
    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!dec_valid && !dec_claim && dec_cmd == 4'h0));
    // R3
    dac_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_side && req_dac && is_mem_cmd(req_cmd)) |=> (dec_claim && !dec_down));
    // R4
    mem_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_side && !mem_en) |=> !dec_claim);
    // R6
    vga_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_side && !req_dac && vga_en &&
         req_addr >= 32'h000A_0000 && req_addr <= 32'h000B_FFFF) |=> !dec_claim);
    // R7
    up_nonpf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_side && up_nonpf) |=> !dec_pref);
    // R8
    no_multi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_claim && !dec_pref) |-> (dec_cmd != 4'hC && dec_cmd != 4'hE));
    // R10
    linear_no_disc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[1:0] == 2'b00) |=> !dec_disc);
    // R2
    down_only_primary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_side) |=> !dec_down);
endmodule

bind mem_fwd_decoder fwd_decoder_chk u_chk (.*);

// File: tb/sim_mem_fwd_decoder.sv
`timescale 1ns/1ps
module sim_mem_fwd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [11:0] cfg_wdata = 12'd0;
    logic        mem_en = 1'b1;
    logic        vga_en = 1'b0;
    logic        up_nonpf = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_side = 1'b0;
    logic        req_dac = 1'b0;
    logic [31:0] req_addr = 32'd0;
    logic [3:0]  req_cmd = 4'd0;
    logic        mwi_fallback = 1'b0;
    logic        dec_valid, dec_claim, dec_down, dec_pref, dec_disc;
    logic [3:0]  dec_cmd;

    int total = 0;
    int bad = 0;
    string phase = "R11";
    bit done = 0;

    always #2 clk = ~clk;

    mem_fwd_decoder u0 (.*);

    // behavioural reference state
    int m_base[4];
    bit e_valid, e_claim, e_down, e_pref, e_disc;
    int e_cmd;

    function automatic bit in_win(int b, int l, logic [31:0] a);
        int hi = int'(a[31:20]);
        return (hi >= b) && (hi <= l);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_base[0] = 'hFFF; m_base[1] = 0; m_base[2] = 'hFFF; m_base[3] = 0;
            {e_valid, e_claim, e_down, e_pref, e_disc} = '0;
            e_cmd = 0;
        end else begin
            bit np, pf, vg, mem;
            np  = in_win(m_base[0], m_base[1], req_addr);
            pf  = in_win(m_base[2], m_base[3], req_addr);
            vg  = vga_en && req_addr >= 32'hA0000 && req_addr <= 32'hBFFFF;
            mem = req_cmd inside {4'h6, 4'h7, 4'hC, 4'hE, 4'hF};
            {e_valid, e_claim, e_down, e_pref, e_disc} = '0;
            e_cmd = 0;
            if (req_valid) begin
                e_valid = 1;
                e_cmd = int'(req_cmd);
                if (mem && !req_side) begin
                    e_claim = !req_dac && mem_en && (np || pf || vg);
                    e_down  = e_claim;
                    e_pref  = e_claim && pf && !np && !vg;
                end else if (mem) begin
                    e_claim = req_dac || !(np || pf || vg);
                    e_pref  = e_claim && !up_nonpf;
                end
                if (e_claim && !e_pref && (e_cmd == 12 || e_cmd == 14)) e_cmd = 6;
                if (e_claim && mwi_fallback && e_cmd == 15) e_cmd = 7;
                e_disc = e_claim && req_addr[1:0] != 2'b00;
            end
            if (cfg_wr_en) m_base[cfg_sel] = int'(cfg_wdata);
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) if (!done) begin
        chk(phase, "valid", int'(dec_valid), int'(e_valid));
        chk(phase, "claim", int'(dec_claim), int'(e_claim));
        chk(phase, "down",  int'(dec_down),  int'(e_down));
        chk(phase, "pref",  int'(dec_pref),  int'(e_pref));
        chk(phase, "cmd",   int'(dec_cmd),   e_cmd);
        chk(phase, "disc",  int'(dec_disc),  int'(e_disc));
    end

    task automatic wr(int sel, int val);
        @(negedge clk);
        cfg_wr_en = 1; cfg_sel = 2'(sel); cfg_wdata = 12'(val);
        @(negedge clk);
        cfg_wr_en = 0;
    endtask

    task automatic req(string tag, bit side, bit dac, logic [31:0] a, logic [3:0] c,
                       bit x_claim, bit x_down, bit x_pref, logic [3:0] x_cmd, bit x_disc);
        @(negedge clk);
        phase = tag;
        req_valid = 1; req_side = side; req_dac = dac; req_addr = a; req_cmd = c;
        @(negedge clk);
        chk(tag, "dir valid", int'(dec_valid), 1);
        chk(tag, "dir claim", int'(dec_claim), int'(x_claim));
        chk(tag, "dir down",  int'(dec_down),  int'(x_down));
        chk(tag, "dir pref",  int'(dec_pref),  int'(x_pref));
        chk(tag, "dir cmd",   int'(dec_cmd),   int'(x_cmd));
        chk(tag, "dir disc",  int'(dec_disc),  int'(x_disc));
        req_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11", "reset valid", int'(dec_valid), 0);
        chk("R11", "reset cmd", int'(dec_cmd), 0);
        // R5 reset windows are inverted
        req("R5", 0, 0, 32'h1000_0000, 4'h6, 0, 0, 0, 4'h6, 0);
        req("R5", 1, 0, 32'h1000_0000, 4'h6, 1, 0, 1, 4'h6, 0);
        wr(0, 'h100); wr(1, 'h1FF); wr(2, 'h400); wr(3, 'h47F);
        // R1 / R12 window edges
        req("R12", 0, 0, 32'h1000_0000, 4'h6, 1, 1, 0, 4'h6, 0);
        req("R12", 0, 0, 32'h1FFF_FFFC, 4'h7, 1, 1, 0, 4'h7, 0);
        req("R12", 0, 0, 32'h0FFF_FFFC, 4'h6, 0, 0, 0, 4'h6, 0);
        req("R1",  0, 0, 32'h2000_0000, 4'h6, 0, 0, 0, 4'h6, 0);
        req("R7",  0, 0, 32'h4000_0000, 4'hE, 1, 1, 1, 4'hE, 0);
        req("R8",  0, 0, 32'h1000_0040, 4'hC, 1, 1, 0, 4'h6, 0);
        // R2 secondary inverse
        req("R2", 1, 0, 32'h1000_0000, 4'h6, 0, 0, 0, 4'h6, 0);
        req("R2", 1, 0, 32'h47FF_FFFC, 4'h6, 0, 0, 0, 4'h6, 0);
        req("R2", 1, 0, 32'h4800_0000, 4'hC, 1, 0, 1, 4'hC, 0);
        up_nonpf = 1;
        req("R7", 1, 0, 32'h3000_0000, 4'hC, 1, 0, 0, 4'h6, 0);
        up_nonpf = 0;
        // R3 dual address
        req("R3", 1, 1, 32'h1000_0000, 4'h7, 1, 0, 1, 4'h7, 0);
        req("R3", 0, 1, 32'h1000_0000, 4'h6, 0, 0, 0, 4'h6, 0);
        // R4 memory enable
        mem_en = 0;
        req("R4", 0, 0, 32'h1000_0000, 4'h6, 0, 0, 0, 4'h6, 0);
        req("R4", 1, 0, 32'h3000_0000, 4'h6, 1, 0, 1, 4'h6, 0);
        mem_en = 1;
        // R6 display range
        vga_en = 1;
        req("R6", 0, 0, 32'h000A_0000, 4'h6, 1, 1, 0, 4'h6, 0);
        req("R6", 0, 0, 32'h000B_FFFC, 4'hC, 1, 1, 0, 4'h6, 0);
        req("R6", 0, 0, 32'h0009_FFFC, 4'h6, 0, 0, 0, 4'h6, 0);
        req("R6", 0, 0, 32'h000C_0000, 4'h6, 0, 0, 0, 4'h6, 0);
        req("R6", 1, 0, 32'h000A_0000, 4'h6, 0, 0, 0, 4'h6, 0);
        req("R6", 1, 0, 32'h000B_FFFC, 4'h6, 0, 0, 0, 4'h6, 0);
        req("R6", 1, 0, 32'h000C_0000, 4'h6, 1, 0, 1, 4'h6, 0);
        vga_en = 0;
        req("R6", 0, 0, 32'h000A_0000, 4'h6, 0, 0, 0, 4'h6, 0);
        // R9 write and invalidate
        mwi_fallback = 1;
        req("R9", 0, 0, 32'h1000_0000, 4'hF, 1, 1, 0, 4'h7, 0);
        mwi_fallback = 0;
        req("R9", 0, 0, 32'h1000_0000, 4'hF, 1, 1, 0, 4'hF, 0);
        // R10 burst order
        req("R10", 0, 0, 32'h1000_0001, 4'h6, 1, 1, 0, 4'h6, 1);
        req("R10", 0, 0, 32'h0FFF_FFFE, 4'h6, 0, 0, 0, 4'h6, 0);
        req("R10", 1, 0, 32'h3000_0002, 4'h6, 1, 0, 1, 4'h6, 1);
        // R11 non-memory command
        req("R11", 0, 0, 32'h1000_0000, 4'h2, 0, 0, 0, 4'h2, 0);
        // R5 inverted after programming
        wr(0, 'h200);
        req("R5", 0, 0, 32'h1800_0000, 4'h6, 0, 0, 0, 4'h6, 0);
        req("R5", 1, 0, 32'h1800_0000, 4'h6, 1, 0, 1, 4'h6, 0);
        // mixed traffic checked by the per-cycle model
        phase = "R1";
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            cfg_wr_en = ($urandom % 20) == 0;
            cfg_sel = 2'($urandom);
            cfg_wdata = 12'($urandom % 'h500);
            mem_en = ($urandom % 8) != 0;
            vga_en = $urandom % 2;
            up_nonpf = $urandom % 2;
            mwi_fallback = $urandom % 2;
            req_valid = ($urandom % 4) != 0;
            req_side = $urandom % 2;
            req_dac = ($urandom % 8) == 0;
            req_cmd = 4'($urandom);
            case ($urandom % 3)
                0: req_addr = 32'h0009_0000 + ($urandom % 32'h40000);
                1: req_addr = {12'($urandom % 'h500), 20'($urandom)};
                default: req_addr = $urandom;
            endcase
        end
        @(negedge clk);
        cfg_wr_en = 0; req_valid = 0;
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule